// File: doc/BRIEF.md
# YCbCr Output Bus Multiplexer

This block places a 4:2:2 luma/chroma pixel stream on two 8-bit output ports. In single-rate mode each pixel period puts a full pair on the ports, one component per port. In double-rate mode the pair is serialised onto port A over two line-clock cycles. That serial stream always opens on a Cb sample and runs Cb, Y, Cr, Y. A shuffle control swaps the luma and chroma roles in both modes.

While only port A carries video, port B is free. It is a sampled input by default, and a control bit turns it into a general-purpose output that drives an 8-bit control value. Each port drives only when both the external enable pin and the register enable are high. The block runs on the double-rate line clock. The pixel clock appears as a strobe that is high for one line-clock cycle in every pixel period.

Top module: `ycbcr_out_mux`

## Requirements
- R1: In single-rate mode with shuffle off, one clock after a strobe with a valid pixel, port A shows that pixel's Y and port B shows its C. Both hold until the next strobe.
- R2: In single-rate mode with shuffle on, port A shows C and port B shows Y with the same timing as R1.
- R3: In double-rate mode with shuffle off, port A shows the chroma sample one clock after the strobe and the Y sample one clock later. A line therefore runs Cb, Y, Cr, Y.
- R4: In double-rate mode, output starts only with a valid pixel whose chroma flag is 0 (Cb; flag 1 means Cr). Valid Cr pixels that arrive before that point, and any invalid pixel, emit 0 in both slots. An invalid pixel clears the lock.
- R5: In double-rate mode with shuffle on, the Y sample comes first and the chroma sample second within each pair.
- R6: While double-rate mode is active, port B's enable is low unless the drive bit is set. When it is set, port B outputs the 8-bit control value, registered, one clock later.
- R7: Each port's enable is the AND of the enable pin and the register enable. The data path keeps running while the ports are disabled, so the newest pixel shows at once when the ports are enabled again.
- R8: Mode and shuffle requests take effect only at a strobe whose pixel is a Cb or invalid. A request seen at a strobe with a valid Cr pixel waits for the next such boundary.
- R9: The port B input pins are registered and shown on the sampled output one clock later, in every mode.
- R10: During reset, port A, port B and the sampled input all read 0. The active mode is single-rate with no shuffle.
- R11: In single-rate mode an invalid pixel puts 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate line clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixStb | input | 1 | Pixel-period strobe: a new pair is presented this cycle |
| validIn | input | 1 | Presented pixel is active video |
| yIn | input | 8 | Luma sample |
| cIn | input | 8 | Chroma sample |
| cIsCr | input | 1 | Chroma phase: 0 Cb, 1 Cr |
| modeDblReq | input | 1 | Requested mode: 1 double-rate 8-bit, 0 single-rate 16-bit |
| shuffleReq | input | 1 | Requested Y/C role swap |
| portBDrive | input | 1 | In double-rate mode, port B drives the control value |
| portBValue | input | 8 | Value that port B drives when it is a general-purpose output |
| oePin | input | 1 | External output enable, active high |
| oeReg | input | 1 | Register output enable, active high |
| portBIn | input | 8 | Port B pad input |
| portAOut | output | 8 | Port A data |
| portAOe | output | 1 | Port A drive enable |
| portBOut | output | 8 | Port B data |
| portBOe | output | 1 | Port B drive enable |
| portBSeen | output | 8 | Registered port B input value |

## Verification
The bench targets the interleave phase. If the phase were reversed, port A would carry Y before chroma. If the design locked on any valid pixel, the line could open on a Cr sample. The bench changes mode and shuffle while a Cr pixel is presented. A design that applied the change at once would split a pair, or leave lanes swapped in the wrong slot. It also disables the ports in the middle of a stream and re-enables them. A design that froze its registers while disabled would show stale data, and a design that used only one of the two enables would keep driving. Port B is exercised as an input and as a driven output, so a design that drove it whenever video left it would be caught.

// File: rtl/ycbcr_out_mux_pkg.sv
package ycbcr_out_mux_pkg;

  // Strobes from the control unit to the datapath for one line-clock cycle.
  typedef struct packed {
    logic loadPair;    // capture the presented Y/C pair this cycle
    logic emitSecond;  // move the held second sample of the pair to port A
    logic dbl;         // active mode for this cycle is double-rate
    logic shuf;        // active luma/chroma role swap for this cycle
    logic emit;        // the captured pair is shown; otherwise blank
  } muxStrobe_t;

endpackage

// File: rtl/ycbcr_out_mux_ctrl.sv
module ycbcr_out_mux_ctrl
  import ycbcr_out_mux_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixStb,
  input  logic       validIn,
  input  logic       cIsCr,
  input  logic       modeDblReq,
  input  logic       shuffleReq,
  output muxStrobe_t strb,
  output logic       dblAct,
  output logic       shufAct,
  output logic       lockQ
);

  logic atBoundary;
  logic dblNext;
  logic shufNext;
  logic lockNext;
  logic pendQ;

  // A pair boundary is a strobe on a Cb pixel or on blanking.
  assign atBoundary = pixStb && (!validIn || !cIsCr);
  assign dblNext    = atBoundary ? modeDblReq : dblAct;
  assign shufNext   = atBoundary ? shuffleReq : shufAct;

  // Lock to the chroma phase: it opens on a valid Cb pixel and closes on blanking.
  assign lockNext = pixStb ? (validIn && (lockQ || !cIsCr)) : lockQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dblAct  <= 1'b0;
      shufAct <= 1'b0;
      lockQ   <= 1'b0;
      pendQ   <= 1'b0;
    end else begin
      dblAct  <= dblNext;
      shufAct <= shufNext;
      lockQ   <= lockNext;
      pendQ   <= pixStb && dblNext;
    end
  end

  always_comb begin
    strb.loadPair   = pixStb;
    strb.emitSecond = pendQ && !pixStb;
    strb.dbl        = dblNext;
    strb.shuf       = shufNext;
    strb.emit       = validIn && (!dblNext || lockNext);
  end

endmodule

// File: rtl/ycbcr_out_mux_datapath.sv
module ycbcr_out_mux_datapath
  import ycbcr_out_mux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  muxStrobe_t        strb,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] cIn,
  input  logic [DATA_W-1:0] portBValue,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] aQ,
  output logic [DATA_W-1:0] bQ,
  output logic [DATA_W-1:0] bSeenQ
);

  localparam int LANES = 2;
  localparam logic [DATA_W-1:0] BLANK = '0;

  logic [DATA_W-1:0] laneVal [LANES];
  logic [DATA_W-1:0] secondQ;

  // Lane 0 feeds port A (or the first slot), lane 1 feeds port B (or the second).
  // With shuffle off, lane 0 is luma in single-rate mode and chroma in double-rate mode.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic pickY;
    assign pickY = ((lane == 0) ^ strb.dbl) ^ strb.shuf;
    assign laneVal[lane] = !strb.emit ? BLANK : (pickY ? yIn : cIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ      <= BLANK;
      secondQ <= BLANK;
    end else if (strb.loadPair) begin
      aQ      <= laneVal[0];
      secondQ <= laneVal[1];
    end else if (strb.emitSecond) begin
      aQ      <= secondQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bQ <= BLANK;
    end else if (strb.dbl) begin
      bQ <= portBValue;
    end else if (strb.loadPair) begin
      bQ <= laneVal[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bSeenQ <= BLANK;
    else       bSeenQ <= portBIn;
  end

endmodule

// File: rtl/ycbcr_out_mux.sv
module ycbcr_out_mux
  import ycbcr_out_mux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixStb,
  input  logic              validIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] cIn,
  input  logic              cIsCr,
  input  logic              modeDblReq,
  input  logic              shuffleReq,
  input  logic              portBDrive,
  input  logic [DATA_W-1:0] portBValue,
  input  logic              oePin,
  input  logic              oeReg,
  input  logic [DATA_W-1:0] portBIn,
  output logic [DATA_W-1:0] portAOut,
  output logic              portAOe,
  output logic [DATA_W-1:0] portBOut,
  output logic              portBOe,
  output logic [DATA_W-1:0] portBSeen
);

  muxStrobe_t strb;
  logic       dblAct;
  logic       shufAct;
  logic       lockQ;
  logic       oeBoth;

  ycbcr_out_mux_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pixStb     (pixStb),
    .validIn    (validIn),
    .cIsCr      (cIsCr),
    .modeDblReq (modeDblReq),
    .shuffleReq (shuffleReq),
    .strb       (strb),
    .dblAct     (dblAct),
    .shufAct    (shufAct),
    .lockQ      (lockQ)
  );

  ycbcr_out_mux_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .yIn        (yIn),
    .cIn        (cIn),
    .portBValue (portBValue),
    .portBIn    (portBIn),
    .aQ         (portAOut),
    .bQ         (portBOut),
    .bSeenQ     (portBSeen)
  );

  assign oeBoth  = oePin && oeReg;
  assign portAOe = oeBoth;
  assign portBOe = oeBoth && (!dblAct || portBDrive);

endmodule

// File: rtl/ycbcr_out_mux_chk.sv
module ycbcr_out_mux_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixStb,
  input logic              validIn,
  input logic              cIsCr,
  input logic [DATA_W-1:0] yIn,
  input logic [DATA_W-1:0] cIn,
  input logic              oePin,
  input logic              oeReg,
  input logic              portBDrive,
  input logic [DATA_W-1:0] portAOut,
  input logic [DATA_W-1:0] portBOut,
  input logic              portAOe,
  input logic              portBOe,
  input logic              dblAct,
  input logic              shufAct,
  input logic              lockQ
);

  p_single_lanes_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && !dblAct && !shufAct)
    |=> (portAOut == $past(yIn)) && (portBOut == $past(cIn)));

  p_single_swap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && !dblAct && shufAct)
    |=> (portAOut == $past(cIn)) && (portBOut == $past(yIn)));

  p_chroma_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && lockQ && dblAct && !shufAct)
    |=> portAOut == $past(cIn));

  p_luma_second_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && lockQ && dblAct && !shufAct) ##1 !pixStb
    |=> portAOut == $past(yIn, 2));

  p_cb_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && !lockQ && dblAct)
    |=> portAOut == '0);

  p_luma_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pixStb && validIn && cIsCr && lockQ && dblAct && shufAct)
    |=> portAOut == $past(yIn));

  p_portb_input_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dblAct && !portBDrive) |-> !portBOe);

  p_oe_and_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(oePin && oeReg) |-> (!portAOe && !portBOe));

  p_boundary_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pixStb || (validIn && cIsCr)) |=> ($stable(dblAct) && $stable(shufAct)));

endmodule

bind ycbcr_out_mux ycbcr_out_mux_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ycbcr_out_mux_tb.sv
`timescale 1ns/1ps
module ycbcr_out_mux_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixStb = 1'b0, validIn = 1'b0, cIsCr = 1'b0;
  logic [7:0] yIn = '0, cIn = '0;
  logic       modeDblReq = 1'b0, shuffleReq = 1'b0, portBDrive = 1'b0;
  logic [7:0] portBValue = '0, portBIn = '0;
  logic       oePin = 1'b1, oeReg = 1'b1;
  logic [7:0] portAOut, portBOut, portBSeen;
  logic       portAOe, portBOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model of the active configuration
  bit mDbl = 1'b0, mShuf = 1'b0, mLock = 1'b0;

  always #10 clk = ~clk;

  ycbcr_out_mux u_dut (
    .clk(clk), .rstN(rstN), .pixStb(pixStb), .validIn(validIn), .yIn(yIn),
    .cIn(cIn), .cIsCr(cIsCr), .modeDblReq(modeDblReq), .shuffleReq(shuffleReq),
    .portBDrive(portBDrive), .portBValue(portBValue), .oePin(oePin), .oeReg(oeReg),
    .portBIn(portBIn), .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut),
    .portBOe(portBOe), .portBSeen(portBSeen)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Entered at a falling edge; leaves at the falling edge two cycles later.
  task automatic pixel(string req, logic [7:0] y, logic [7:0] c, bit cr, bit v);
    logic [7:0] e1, e2, eb;
    bit emit;
    if (!v || !cr) begin mDbl = modeDblReq; mShuf = shuffleReq; end
    mLock = v && (mLock || !cr);
    emit  = v && (!mDbl || mLock);
    if (mDbl) begin
      e1 = !emit ? 8'h00 : (mShuf ? y : c);
      e2 = !emit ? 8'h00 : (mShuf ? c : y);
      eb = portBValue;
    end else begin
      e1 = !emit ? 8'h00 : (mShuf ? c : y);
      e2 = e1;
      eb = !emit ? 8'h00 : (mShuf ? y : c);
    end
    pixStb = 1'b1; yIn = y; cIn = c; cIsCr = cr; validIn = v;
    @(negedge clk);
    pixStb = 1'b0;
    chk(req, "portA slot1", portAOut, e1);
    chk(req, "portB", portBOut, eb);
    chk(req, "portAOe", {7'b0, portAOe}, {7'b0, oePin & oeReg});
    chk(req, "portBOe", {7'b0, portBOe}, {7'b0, oePin & oeReg & (!mDbl | portBDrive)});
    @(negedge clk);
    chk(req, "portA slot2", portAOut, e2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10", "portA in reset", portAOut, 8'h00);
    chk("R10", "portB in reset", portBOut, 8'h00);
    chk("R10", "seen in reset", portBSeen, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    pixel("R10", 8'h21, 8'h43, 1'b1, 1'b1);
  endtask

  task automatic t_single();
    pixel("R1", 8'h50, 8'h60, 1'b0, 1'b1);
    pixel("R1", 8'h51, 8'h70, 1'b1, 1'b1);
    pixel("R11", 8'h99, 8'h88, 1'b0, 1'b0);
    shuffleReq = 1'b1;
    pixel("R2", 8'h52, 8'h61, 1'b0, 1'b1);
    pixel("R2", 8'h53, 8'h71, 1'b1, 1'b1);
    shuffleReq = 1'b0;
    pixel("R2", 8'h54, 8'h62, 1'b0, 1'b1);
  endtask

  task automatic t_boundary();
    // Request double-rate on a Cr pixel: must stay single-rate.
    pixel("R8", 8'h30, 8'h31, 1'b0, 1'b1);
    modeDblReq = 1'b1;
    pixel("R8", 8'h32, 8'h33, 1'b1, 1'b1);
    chk("R8", "portB still video", portBOut, 8'h33);
    pixel("R8", 8'h34, 8'h35, 1'b0, 1'b1);
    pixel("R3", 8'h36, 8'h37, 1'b1, 1'b1);
    pixel("R3", 8'h38, 8'h39, 1'b0, 1'b1);
  endtask

  task automatic t_cb_start();
    pixel("R4", 8'h00, 8'h80, 1'b0, 1'b0);
    pixel("R4", 8'h41, 8'h42, 1'b1, 1'b1);
    pixel("R4", 8'h43, 8'h44, 1'b0, 1'b1);
    pixel("R4", 8'h45, 8'h46, 1'b1, 1'b1);
    shuffleReq = 1'b1;
    pixel("R5", 8'h47, 8'h48, 1'b1, 1'b1);
    pixel("R5", 8'h49, 8'h4a, 1'b0, 1'b1);
    pixel("R5", 8'h4b, 8'h4c, 1'b1, 1'b1);
    shuffleReq = 1'b0;
  endtask

  task automatic t_portb();
    portBDrive = 1'b0; portBValue = 8'h5a;
    pixel("R6", 8'h11, 8'h12, 1'b0, 1'b1);
    portBDrive = 1'b1;
    pixel("R6", 8'h13, 8'h14, 1'b1, 1'b1);
    portBValue = 8'hc3;
    @(negedge clk);
    chk("R6", "driven value", portBOut, 8'hc3);
    chk("R6", "driven oe", {7'b0, portBOe}, 8'h01);
    portBIn = 8'h3c;
    @(negedge clk);
    chk("R9", "sampled input", portBSeen, 8'h3c);
    portBIn = 8'ha5;
    @(negedge clk);
    chk("R9", "sampled input", portBSeen, 8'ha5);
  endtask

  task automatic t_oe();
    oeReg = 1'b0;
    pixel("R7", 8'h61, 8'h62, 1'b0, 1'b1);
    oeReg = 1'b1; oePin = 1'b0;
    pixel("R7", 8'h63, 8'h64, 1'b1, 1'b1);
    oePin = 1'b1;
    chk("R7", "newest Y after enable", portAOut, 8'h63);
    pixel("R7", 8'h65, 8'h66, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_boundary();
    t_cb_start();
    t_portb();
    t_oe();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule